// File: doc/BRIEF.md
# Cache Trace Performance Monitor

This block watches the trace strobes that a processor emits for its data cache and its instruction cache and turns them into performance figures. It never drives the caches. For each cache it counts accesses, hits and misses. For the data cache it also splits accesses into reads and writes. It pairs each missing request with the later completion strobe and measures the miss latency. The latency feeds a running total and a largest-value register for each cache.

Each cache side is run by a two-state machine. `ST_IDLE` means no miss is outstanding and `ST_WAIT` means one miss is pending. The transitions are: miss start (`ST_IDLE` to `ST_WAIT` on a request without hit), miss done (`ST_WAIT` to `ST_IDLE` on a completion strobe with no new miss request), chain (`ST_WAIT` to `ST_WAIT` when a completion strobe and a new miss request share a cycle), and hold (each state stays when none of these apply). A sticky protocol-error flag records any break of the strobe ordering rules. The flag stays set until reset.

All results are registered and appear one clock after the strobes that cause them. Counters saturate at all ones and never wrap.

Top module: `ctp_cache_monitor`

## Requirements
- R1: After reset (`rst_n` low, asynchronous) every counter, total and maximum reads zero and both error flags read 0.
- R2: Each cycle with a request raises that side's access count by one. It raises the hit count when the hit strobe is 1 and the miss count when it is 0, so hit plus miss always equals access.
- R3: A data-side request with `dside_is_read`=1 raises the read count and one with `dside_is_read`=0 raises the write count. `dside_is_read` has no effect in a cycle without a request.
- R4: Miss latency is the number of cycles from the miss request to its completion strobe. A request in cycle t that completes in cycle t+n gives n. This is added to the side's latency total.
- R5: The latency maximum holds the largest latency seen on that side and saturates at 65535.
- R6: A request while a miss is pending, in a cycle without the completion strobe, sets the side's error flag. A miss request in the same cycle as the completion strobe is accepted as a new pending miss.
- R7: A completion strobe with no pending miss sets the error flag. The one exception is the instruction side, where completion may coincide with a hitting request. A data-side completion together with a hit is an error, and so is completion in the same cycle as a missing request.
- R8: A hit strobe without a request sets the side's error flag.
- R9: Error flags stay set until reset, and counters never decrease or wrap.
- R10: The two sides are independent: strobes on one side never change the other side's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dside_req | input | 1 | Data cache access request strobe |
| dside_hit | input | 1 | Data cache hit strobe |
| dside_done | input | 1 | Data cache miss completion strobe |
| dside_is_read | input | 1 | Data cache access is a read (valid with request) |
| iside_req | input | 1 | Instruction cache fetch request strobe |
| iside_hit | input | 1 | Instruction cache hit strobe |
| iside_done | input | 1 | Instruction cache completion strobe |
| dside_acc_cnt | output | 32 | Data side access count |
| dside_hit_cnt | output | 32 | Data side hit count |
| dside_miss_cnt | output | 32 | Data side miss count |
| dside_read_cnt | output | 32 | Data side read count |
| dside_write_cnt | output | 32 | Data side write count |
| dside_lat_total | output | 32 | Data side summed miss latency |
| dside_lat_max | output | 16 | Data side largest miss latency |
| dside_proto_err | output | 1 | Data side sticky protocol error |
| iside_acc_cnt | output | 32 | Instruction side access count |
| iside_hit_cnt | output | 32 | Instruction side hit count |
| iside_miss_cnt | output | 32 | Instruction side miss count |
| iside_lat_total | output | 32 | Instruction side summed miss latency |
| iside_lat_max | output | 16 | Instruction side largest miss latency |
| iside_proto_err | output | 1 | Instruction side sticky protocol error |

## Verification
Every counter, latency result and error flag is due exactly one clock after the edge that samples the strobes causing it. A latency is due one clock after its completion strobe. The bench drives strobes on the falling edge. After the last strobe of a scenario it drives one idle falling edge and then reads the outputs, so each result has passed through exactly one register. Sticky flags are read again after further idle cycles. The long instruction-side miss runs past 65535 cycles so that the maximum can be checked at its saturated value.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } side_state_e;
endpackage

// File: rtl/ctp_sat_counter.sv
module ctp_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (inc && value != TOP) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/ctp_side_monitor.sv
module ctp_side_monitor
    import ctp_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int TOT_W       = 32,
    parameter int MAX_W       = 16,
    parameter bit HIT_DONE_OK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             hit,
    input  logic             done,
    output logic [CNT_W-1:0] acc_cnt,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt,
    output logic [TOT_W-1:0] lat_total,
    output logic [MAX_W-1:0] lat_max,
    output logic             proto_err
);
    localparam int N_CNT = 3;
    localparam logic [TOT_W-1:0] RUN_TOP = {TOT_W{1'b1}};
    localparam logic [MAX_W-1:0] MAX_TOP = {MAX_W{1'b1}};

    side_state_e state, state_nx;
    logic        miss_req, start_miss, done_miss, err_ev;
    logic [TOT_W-1:0] run_cnt;
    logic [TOT_W:0]   sum_ext;
    logic [MAX_W-1:0] run_clip;
    logic [N_CNT-1:0] inc_vec;
    logic [CNT_W-1:0] cnt_arr [N_CNT];

    assign miss_req = req && !hit;
    assign inc_vec  = {miss_req, req && hit, req};

    generate
        for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
            ctp_sat_counter #(.W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (inc_vec[g]),
                .value (cnt_arr[g])
            );
        end
    endgenerate

    assign acc_cnt  = cnt_arr[0];
    assign hit_cnt  = cnt_arr[1];
    assign miss_cnt = cnt_arr[2];

    // Next-state and event decode
    always_comb begin
        state_nx   = state;
        start_miss = 1'b0;
        done_miss  = 1'b0;
        err_ev     = hit && !req;
        unique case (state)
            ST_IDLE: begin
                if (done && !(HIT_DONE_OK && req && hit)) begin
                    err_ev = 1'b1;
                end
                if (miss_req) begin
                    start_miss = 1'b1;
                    state_nx   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (done) begin
                    done_miss = 1'b1;
                    if (miss_req) begin
                        start_miss = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end else if (req) begin
                    err_ev = 1'b1;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    assign sum_ext  = {1'b0, lat_total} + {1'b0, run_cnt};
    assign run_clip = (run_cnt > TOT_W'(MAX_TOP)) ? MAX_TOP : run_cnt[MAX_W-1:0];

    // Outputs: error flag and latency statistics
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            proto_err <= 1'b0;
            run_cnt   <= '0;
            lat_total <= '0;
            lat_max   <= '0;
        end else begin
            if (err_ev) begin
                proto_err <= 1'b1;
            end
            if (start_miss) begin
                run_cnt <= TOT_W'(1);
            end else if (state == ST_WAIT && run_cnt != RUN_TOP) begin
                run_cnt <= run_cnt + 1'b1;
            end
            if (done_miss) begin
                lat_total <= sum_ext[TOT_W] ? RUN_TOP : sum_ext[TOT_W-1:0];
                if (run_clip > lat_max) begin
                    lat_max <= run_clip;
                end
            end
        end
    end
endmodule

// File: rtl/ctp_cache_monitor.sv
module ctp_cache_monitor #(
    parameter int CNT_W = 32,
    parameter int TOT_W = 32,
    parameter int MAX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dside_req,
    input  logic             dside_hit,
    input  logic             dside_done,
    input  logic             dside_is_read,
    input  logic             iside_req,
    input  logic             iside_hit,
    input  logic             iside_done,
    output logic [CNT_W-1:0] dside_acc_cnt,
    output logic [CNT_W-1:0] dside_hit_cnt,
    output logic [CNT_W-1:0] dside_miss_cnt,
    output logic [CNT_W-1:0] dside_read_cnt,
    output logic [CNT_W-1:0] dside_write_cnt,
    output logic [TOT_W-1:0] dside_lat_total,
    output logic [MAX_W-1:0] dside_lat_max,
    output logic             dside_proto_err,
    output logic [CNT_W-1:0] iside_acc_cnt,
    output logic [CNT_W-1:0] iside_hit_cnt,
    output logic [CNT_W-1:0] iside_miss_cnt,
    output logic [TOT_W-1:0] iside_lat_total,
    output logic [MAX_W-1:0] iside_lat_max,
    output logic             iside_proto_err
);
    // Data side: completion only ever closes a miss
    ctp_side_monitor #(
        .CNT_W(CNT_W), .TOT_W(TOT_W), .MAX_W(MAX_W), .HIT_DONE_OK(1'b0)
    ) u_dside (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (dside_req),
        .hit       (dside_hit),
        .done      (dside_done),
        .acc_cnt   (dside_acc_cnt),
        .hit_cnt   (dside_hit_cnt),
        .miss_cnt  (dside_miss_cnt),
        .lat_total (dside_lat_total),
        .lat_max   (dside_lat_max),
        .proto_err (dside_proto_err)
    );

    // Instruction side: completion may accompany a hitting request
    ctp_side_monitor #(
        .CNT_W(CNT_W), .TOT_W(TOT_W), .MAX_W(MAX_W), .HIT_DONE_OK(1'b1)
    ) u_iside (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (iside_req),
        .hit       (iside_hit),
        .done      (iside_done),
        .acc_cnt   (iside_acc_cnt),
        .hit_cnt   (iside_hit_cnt),
        .miss_cnt  (iside_miss_cnt),
        .lat_total (iside_lat_total),
        .lat_max   (iside_lat_max),
        .proto_err (iside_proto_err)
    );

    ctp_sat_counter #(.W(CNT_W)) u_rd_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (dside_req && dside_is_read),
        .value (dside_read_cnt)
    );

    ctp_sat_counter #(.W(CNT_W)) u_wr_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (dside_req && !dside_is_read),
        .value (dside_write_cnt)
    );
endmodule

// File: rtl/ctp_monitor_checker.sv
module ctp_monitor_checker #(
    parameter int CNT_W = 32,
    parameter int MAX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dside_req,
    input logic             dside_hit,
    input logic             iside_req,
    input logic             iside_hit,
    input logic [CNT_W-1:0] dside_acc_cnt,
    input logic [CNT_W-1:0] dside_hit_cnt,
    input logic [CNT_W-1:0] dside_miss_cnt,
    input logic [CNT_W-1:0] dside_read_cnt,
    input logic [CNT_W-1:0] dside_write_cnt,
    input logic [MAX_W-1:0] dside_lat_max,
    input logic             dside_proto_err,
    input logic [CNT_W-1:0] iside_acc_cnt,
    input logic [CNT_W-1:0] iside_hit_cnt,
    input logic [CNT_W-1:0] iside_miss_cnt,
    input logic [MAX_W-1:0] iside_lat_max,
    input logic             iside_proto_err
);
    localparam logic [CNT_W-1:0] CTOP = {CNT_W{1'b1}};

    p_sum_dside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dside_acc_cnt != CTOP) |->
        ({1'b0, dside_acc_cnt} == {1'b0, dside_hit_cnt} + {1'b0, dside_miss_cnt}));

    p_sum_iside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iside_acc_cnt != CTOP) |->
        ({1'b0, iside_acc_cnt} == {1'b0, iside_hit_cnt} + {1'b0, iside_miss_cnt}));

    p_step_dside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dside_req && dside_acc_cnt != CTOP) |=>
        (dside_acc_cnt == $past(dside_acc_cnt) + 1'b1));

    p_rw_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dside_acc_cnt != CTOP) |->
        ({1'b0, dside_acc_cnt} == {1'b0, dside_read_cnt} + {1'b0, dside_write_cnt}));

    p_max_mono_dside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dside_lat_max >= $past(dside_lat_max)));

    p_max_mono_iside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (iside_lat_max >= $past(iside_lat_max)));

    p_hit_alone_dside_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dside_hit && !dside_req) |=> dside_proto_err);

    p_hit_alone_iside_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iside_hit && !iside_req) |=> iside_proto_err);

    p_err_sticky_dside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dside_proto_err |=> dside_proto_err);

    p_err_sticky_iside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iside_proto_err |=> iside_proto_err);

    p_no_wrap_iside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (iside_acc_cnt >= $past(iside_acc_cnt)));
endmodule

bind ctp_cache_monitor ctp_monitor_checker #(.CNT_W(CNT_W), .MAX_W(MAX_W)) u_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .dside_req       (dside_req),
    .dside_hit       (dside_hit),
    .iside_req       (iside_req),
    .iside_hit       (iside_hit),
    .dside_acc_cnt   (dside_acc_cnt),
    .dside_hit_cnt   (dside_hit_cnt),
    .dside_miss_cnt  (dside_miss_cnt),
    .dside_read_cnt  (dside_read_cnt),
    .dside_write_cnt (dside_write_cnt),
    .dside_lat_max   (dside_lat_max),
    .dside_proto_err (dside_proto_err),
    .iside_acc_cnt   (iside_acc_cnt),
    .iside_hit_cnt   (iside_hit_cnt),
    .iside_miss_cnt  (iside_miss_cnt),
    .iside_lat_max   (iside_lat_max),
    .iside_proto_err (iside_proto_err)
);

// File: tb/tb_ctp_cache_monitor.sv
module tb_ctp_cache_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dr = 0, dh = 0, dd = 0, drd = 0, ir = 0, ih = 0, id = 0;
    logic [31:0] d_acc, d_hit, d_miss, d_rd, d_wr, d_tot, i_acc, i_hit, i_miss, i_tot;
    logic [15:0] d_max, i_max;
    logic d_err, i_err;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ctp_cache_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .dside_req(dr), .dside_hit(dh), .dside_done(dd), .dside_is_read(drd),
        .iside_req(ir), .iside_hit(ih), .iside_done(id),
        .dside_acc_cnt(d_acc), .dside_hit_cnt(d_hit), .dside_miss_cnt(d_miss),
        .dside_read_cnt(d_rd), .dside_write_cnt(d_wr), .dside_lat_total(d_tot),
        .dside_lat_max(d_max), .dside_proto_err(d_err),
        .iside_acc_cnt(i_acc), .iside_hit_cnt(i_hit), .iside_miss_cnt(i_miss),
        .iside_lat_total(i_tot), .iside_lat_max(i_max), .iside_proto_err(i_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle of strobes on the falling edge
    task automatic put(input logic a, b, c, e, f, g, h);
        @(negedge clk);
        dr = a; dh = b; dd = c; drd = e; ir = f; ih = g; id = h;
    endtask

    task automatic idle();
        put(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        dr = 0; dh = 0; dd = 0; drd = 0; ir = 0; ih = 0; id = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        idle();
        chk("R1 d_acc", d_acc, 0);   chk("R1 d_rd", d_rd, 0);
        chk("R1 d_tot", d_tot, 0);   chk("R1 i_acc", i_acc, 0);
        chk("R1 i_max", 32'(i_max), 0);
        chk("R1 d_err", 32'(d_err), 0); chk("R1 i_err", 32'(i_err), 0);
    endtask

    task automatic t_hits();
        do_reset();
        put(1, 1, 0, 1, 1, 1, 1);
        put(1, 1, 0, 1, 0, 0, 0);
        put(1, 1, 0, 1, 1, 1, 1);
        idle();
        chk("R2 d_acc", d_acc, 3);  chk("R2 d_hit", d_hit, 3);
        chk("R2 d_miss", d_miss, 0); chk("R3 d_rd", d_rd, 3);
        chk("R2 i_acc", i_acc, 2);  chk("R2 i_hit", i_hit, 2);
        chk("R7 i_err hit+done", 32'(i_err), 0);
        chk("R2 d_err", 32'(d_err), 0);
    endtask

    task automatic t_latency();
        do_reset();
        put(1, 0, 0, 0, 0, 0, 0);
        repeat (2) idle();
        put(0, 0, 1, 0, 0, 0, 0);            // latency 3
        put(1, 0, 0, 1, 0, 0, 0);
        repeat (4) idle();
        put(0, 0, 1, 0, 0, 0, 0);            // latency 5
        put(1, 0, 0, 1, 0, 0, 0);
        idle();
        put(0, 0, 1, 0, 0, 0, 0);            // latency 2
        idle();
        chk("R4 d_tot", d_tot, 10);  chk("R5 d_max", 32'(d_max), 5);
        chk("R2 d_miss", d_miss, 3); chk("R3 d_wr", d_wr, 1);
        chk("R3 d_rd", d_rd, 2);     chk("R4 d_err", 32'(d_err), 0);
        // chained miss: done and new miss in one cycle
        put(1, 0, 0, 0, 0, 0, 0);
        idle();
        put(1, 0, 1, 0, 0, 0, 0);            // latency 2, new miss
        repeat (3) idle();
        put(0, 0, 1, 0, 0, 0, 0);            // latency 4
        idle();
        chk("R6 chain d_tot", d_tot, 16); chk("R6 chain d_err", 32'(d_err), 0);
        chk("R6 chain d_miss", d_miss, 5); chk("R10 i_acc", i_acc, 0);
    endtask

    task automatic t_overlap();
        do_reset();
        put(1, 0, 0, 0, 0, 0, 0);
        put(1, 1, 0, 0, 0, 0, 0);
        idle();
        chk("R6 d_err overlap", 32'(d_err), 1);
        chk("R10 i_err", 32'(i_err), 0);
    endtask

    task automatic t_orphan();
        do_reset();
        put(0, 0, 1, 0, 1, 1, 1);
        idle();
        chk("R7 d_err orphan", 32'(d_err), 1);
        chk("R7 i_err legal", 32'(i_err), 0);
        repeat (5) idle();
        chk("R9 d_err sticky", 32'(d_err), 1);
        do_reset();
        put(1, 1, 1, 0, 0, 0, 0);
        idle();
        chk("R7 d_err hit+done", 32'(d_err), 1);
        do_reset();
        put(0, 0, 0, 0, 1, 0, 1);
        idle();
        chk("R7 i_err miss+done", 32'(i_err), 1);
    endtask

    task automatic t_hit_alone();
        do_reset();
        put(0, 0, 0, 0, 0, 1, 0);
        idle();
        chk("R8 i_err", 32'(i_err), 1);
        chk("R10 d_err", 32'(d_err), 0);
    endtask

    task automatic t_read_ignored();
        do_reset();
        repeat (4) put(0, 0, 0, 1, 0, 0, 0);
        idle();
        chk("R3 d_rd idle", d_rd, 0); chk("R3 d_wr idle", d_wr, 0);
        chk("R3 d_acc idle", d_acc, 0);
    endtask

    task automatic t_long_miss();
        do_reset();
        put(0, 0, 0, 0, 1, 0, 0);
        repeat (69999) idle();
        put(0, 0, 0, 0, 0, 0, 1);            // latency 70000
        idle();
        chk("R4 i_tot", i_tot, 70000);
        chk("R5 i_max sat", 32'(i_max), 65535);
        chk("R2 i_miss", i_miss, 1);
        chk("R10 d_tot", d_tot, 0);
    endtask

    initial begin
        t_reset();
        t_hits();
        t_latency();
        t_overlap();
        t_orphan();
        t_hit_alone();
        t_read_ignored();
        t_long_miss();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule